// File: doc/BRIEF.md
# Subcarrier Frame Encoder

This block drives the load-modulation output of a contactless tag while it answers a reader. It runs on the 13.56 MHz carrier clock. A response of 1 to `MAX_BITS` data bits is loaded with a single start pulse. The block then plays out a fixed 8-slot opening marker, two slots for every data bit, and a fixed 8-slot closing marker, all on one output pin.

Every slot lasts 256 carrier clocks, which is about 18.9 us. A slot marked 1 fills its whole duration with a square subcarrier at one sixty-fourth of the carrier. A slot marked 0 leaves the output low.

CRC generation and the content of the response belong to the caller. The caller waits for `done_o` before it loads the next response.

Top module: `subcarrier_frame_encoder`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `mod_o` are all low.
- R2: A start pulse seen while idle, with `nbits_i` from 1 to `MAX_BITS`, raises `busy_o` in the next cycle. `busy_o` then stays high for exactly (16 + 2*`nbits_i`) * 256 cycles.
- R3: Every slot lasts 256 clocks. In a slot of value 1, `mod_o` is high for the first 32 clocks of each 64-clock period, so it toggles every 32 clocks and starts high at the slot boundary.
- R4: In a slot of value 0, `mod_o` stays low for all 256 clocks.
- R5: The first eight slots of a frame take the values 0,0,0,1,1,1,0,1, in that time order.
- R6: Data bits go out least significant bit first, starting at `data_i` bit 0. A data 1 takes slot values 0 then 1, and a data 0 takes slot values 1 then 0.
- R7: The last eight slots of a frame take the values 1,0,1,1,1,0,0,0, in that time order.
- R8: `done_o` is high for exactly one cycle, the first cycle in which `busy_o` is low again after a frame.
- R9: A start pulse that arrives while `busy_o` is high is ignored. The frame in progress keeps its content and its length.
- R10: A start pulse with `nbits_i` equal to 0 or greater than `MAX_BITS` is ignored. `busy_o` stays low and `mod_o` stays low.
- R11: `mod_o` is low whenever `busy_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Carrier-rate clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request to send a response |
| nbits_i | input | $clog2(MAX_BITS+1) | Number of data bits, sampled with start_i |
| data_i | input | MAX_BITS | Response bits, bit 0 sent first, sampled with start_i |
| busy_o | output | 1 | High while a frame is being sent |
| done_o | output | 1 | One-cycle pulse after the final slot |
| mod_o | output | 1 | Load-modulation output |

## Verification
The bench compares `mod_o` in every cycle of each frame against a slot model built from the requirements. Frames of one bit and of `MAX_BITS` bits show whether the last data bit is counted correctly: an off-by-one in the bit counter drops or repeats a data slot pair and moves the closing marker by two slots. All-zero and all-one payloads show whether a design swapped the two halves of the bit code or sent the data most significant bit first.

A start pulse injected in the middle of a frame catches a design that reloads its data or restarts its timer. Requests with a bit count of zero or seventeen catch a design that would send an endless frame, or a frame padded out to full length. Checks of `done_o` in the cycle after the final slot, and in the cycle after that, catch a pulse that is late or that lasts more than one cycle.

// File: rtl/sfe_pkg.sv
package sfe_pkg;

    // Frame sections in the order they are sent.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_SOF  = 2'd1,
        PH_DATA = 2'd2,
        PH_EOF  = 2'd3
    } phase_e;

    // Marker slot values; the most significant bit goes on the air first.
    localparam logic [7:0] OPEN_MARK  = 8'b0001_1101;
    localparam logic [7:0] CLOSE_MARK = 8'b1011_1000;
    localparam int         MARK_SLOTS = 8;

endpackage

// File: rtl/sfe_slot_timer.sv
module sfe_slot_timer #(
    parameter int SLOT_CLKS = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic slot_end_o
);
    localparam int CNT_W = $clog2(SLOT_CLKS);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SLOT_CLKS - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (!run_i) begin
            tmr_d.cnt = '0;
        end else if (tmr_q.cnt == LAST) begin
            tmr_d.cnt = '0;
        end else begin
            tmr_d.cnt = tmr_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign slot_end_o = run_i && (tmr_q.cnt == LAST);

endmodule

// File: rtl/sfe_subcarrier.sv
module sfe_subcarrier #(
    parameter int HALF_PERIOD = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active_i,
    input  logic slot_end_i,
    input  logic slot_bit_i,
    output logic mod_o
);
    localparam int HC_W = $clog2(HALF_PERIOD);
    localparam logic [HC_W-1:0] HC_LAST = HC_W'(HALF_PERIOD - 1);

    typedef struct packed {
        logic [HC_W-1:0] hc;
        logic            low_half;
    } sc_t;

    sc_t sc_d, sc_q;

    always_comb begin
        sc_d = sc_q;
        if (!active_i || slot_end_i) begin
            // every slot starts in its high half
            sc_d.hc       = '0;
            sc_d.low_half = 1'b0;
        end else if (sc_q.hc == HC_LAST) begin
            sc_d.hc       = '0;
            sc_d.low_half = ~sc_q.low_half;
        end else begin
            sc_d.hc = sc_q.hc + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sc_q <= '0;
        else        sc_q <= sc_d;
    end

    assign mod_o = active_i && slot_bit_i && !sc_q.low_half;

endmodule

// File: rtl/sfe_slot_seq.sv
module sfe_slot_seq
    import sfe_pkg::*;
#(
    parameter int MAX_BITS = 16,
    parameter int NB_W     = $clog2(MAX_BITS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [NB_W-1:0]     nbits_i,
    input  logic [MAX_BITS-1:0] data_i,
    input  logic                slot_end_i,
    output logic                active_o,
    output logic                slot_bit_o,
    output logic                done_o
);
    localparam int IDX_W = $clog2(MARK_SLOTS);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(MARK_SLOTS - 1);
    localparam logic [NB_W-1:0]  CNT_MAX  = NB_W'(MAX_BITS);

    typedef struct packed {
        phase_e              phase;
        logic [IDX_W-1:0]    idx;
        logic                second;
        logic [NB_W-1:0]     left;
        logic [MAX_BITS-1:0] data;
        logic                done;
    } seq_t;

    seq_t seq_d, seq_q;
    logic req_ok;

    assign req_ok = start_i && (nbits_i != '0) && (nbits_i <= CNT_MAX);

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        unique case (seq_q.phase)
            PH_IDLE: begin
                if (req_ok) begin
                    seq_d.phase  = PH_SOF;
                    seq_d.idx    = '0;
                    seq_d.second = 1'b0;
                    seq_d.left   = nbits_i;
                    seq_d.data   = data_i;
                end
            end
            PH_SOF: begin
                if (slot_end_i) begin
                    if (seq_q.idx == IDX_LAST) begin
                        seq_d.phase = PH_DATA;
                        seq_d.idx   = '0;
                    end else begin
                        seq_d.idx = seq_q.idx + 1'b1;
                    end
                end
            end
            PH_DATA: begin
                if (slot_end_i) begin
                    if (!seq_q.second) begin
                        seq_d.second = 1'b1;
                    end else begin
                        seq_d.second = 1'b0;
                        seq_d.data   = seq_q.data >> 1;
                        seq_d.left   = seq_q.left - 1'b1;
                        if (seq_q.left == NB_W'(1)) begin
                            seq_d.phase = PH_EOF;
                            seq_d.idx   = '0;
                        end
                    end
                end
            end
            PH_EOF: begin
                if (slot_end_i) begin
                    if (seq_q.idx == IDX_LAST) begin
                        seq_d.phase = PH_IDLE;
                        seq_d.idx   = '0;
                        seq_d.done  = 1'b1;
                    end else begin
                        seq_d.idx = seq_q.idx + 1'b1;
                    end
                end
            end
            default: seq_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{phase: PH_IDLE, default: '0};
        else        seq_q <= seq_d;
    end

    always_comb begin
        unique case (seq_q.phase)
            PH_SOF:  slot_bit_o = OPEN_MARK[IDX_LAST - seq_q.idx];
            PH_DATA: slot_bit_o = seq_q.second ? seq_q.data[0] : ~seq_q.data[0];
            PH_EOF:  slot_bit_o = CLOSE_MARK[IDX_LAST - seq_q.idx];
            default: slot_bit_o = 1'b0;
        endcase
    end

    assign active_o = (seq_q.phase != PH_IDLE);
    assign done_o   = seq_q.done;

endmodule

// File: rtl/subcarrier_frame_encoder.sv
module subcarrier_frame_encoder #(
    parameter int MAX_BITS    = 16,
    parameter int SLOT_CLKS   = 256,
    parameter int HALF_PERIOD = 32,
    parameter int NB_W        = $clog2(MAX_BITS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [NB_W-1:0]     nbits_i,
    input  logic [MAX_BITS-1:0] data_i,
    output logic                busy_o,
    output logic                done_o,
    output logic                mod_o
);
    logic active;
    logic slot_end;
    logic slot_bit;

    sfe_slot_seq #(
        .MAX_BITS (MAX_BITS),
        .NB_W     (NB_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .nbits_i    (nbits_i),
        .data_i     (data_i),
        .slot_end_i (slot_end),
        .active_o   (active),
        .slot_bit_o (slot_bit),
        .done_o     (done_o)
    );

    sfe_slot_timer #(
        .SLOT_CLKS (SLOT_CLKS)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (active),
        .slot_end_o (slot_end)
    );

    sfe_subcarrier #(
        .HALF_PERIOD (HALF_PERIOD)
    ) u_sc (
        .clk        (clk),
        .rst_n      (rst_n),
        .active_i   (active),
        .slot_end_i (slot_end),
        .slot_bit_i (slot_bit),
        .mod_o      (mod_o)
    );

    assign busy_o = active;

endmodule

// File: rtl/sfe_checker.sv
module sfe_checker #(
    parameter int MAX_BITS    = 16,
    parameter int HALF_PERIOD = 32,
    parameter int NB_W        = $clog2(MAX_BITS + 1)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start_i,
    input logic [NB_W-1:0] nbits_i,
    input logic            busy_o,
    input logic            done_o,
    input logic            mod_o
);
    localparam int HC_W = $clog2(HALF_PERIOD);

    logic [HC_W-1:0] grid_q;
    logic            bad_req;
    logic            good_req;

    // free-running phase within a half period, counted from the first busy cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       grid_q <= '0;
        else if (!busy_o) grid_q <= '0;
        else              grid_q <= grid_q + 1'b1;
    end

    assign bad_req  = start_i && ((nbits_i == '0) || (nbits_i > NB_W'(MAX_BITS)));
    assign good_req = start_i && !bad_req;

    a_r2_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && good_req) |=> busy_o);

    a_r2_end_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);

    a_r3_toggle_grid: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && (grid_q != '0)) |-> $stable(mod_o));

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    a_r10_bad_count: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && bad_req) |=> !busy_o);

    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !mod_o);

endmodule

bind subcarrier_frame_encoder sfe_checker #(
    .MAX_BITS    (MAX_BITS),
    .HALF_PERIOD (HALF_PERIOD),
    .NB_W        (NB_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .nbits_i (nbits_i),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .mod_o   (mod_o)
);

// File: tb/subcarrier_frame_encoder_bench.sv
`timescale 1ns/1ps
module subcarrier_frame_encoder_bench;
    localparam int MAXB = 16;
    localparam int NBW  = 5;
    localparam int SLOT = 256;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start_i = 1'b0;
    logic [NBW-1:0]  nbits_i = '0;
    logic [MAXB-1:0] data_i = '0;
    logic            busy_o, done_o, mod_o;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    subcarrier_frame_encoder u_subcarrier_frame_encoder (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .nbits_i (nbits_i),
        .data_i  (data_i),
        .busy_o  (busy_o),
        .done_o  (done_o),
        .mod_o   (mod_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Runs one frame and compares every cycle against the slot model.
    task automatic run_frame(input int n, input logic [MAXB-1:0] d, input bit poke);
        logic [7:0] open_m  = 8'b0001_1101;
        logic [7:0] close_m = 8'b1011_1000;
        int total = 16 + 2 * n;
        logic slots[0:47];
        int err_open = 0, err_data = 0, err_close = 0;
        int err_on = 0, err_off = 0, err_busy = 0;
        for (int k = 0; k < 8; k++) begin
            slots[k]             = open_m[7-k];
            slots[8 + 2*n + k]   = close_m[7-k];
        end
        for (int b = 0; b < n; b++) begin
            slots[8 + 2*b]     = ~d[b];
            slots[8 + 2*b + 1] =  d[b];
        end
        start_i = 1'b1; nbits_i = NBW'(n); data_i = d;
        @(negedge clk);
        start_i = 1'b0;
        for (int j = 0; j < total * SLOT; j++) begin
            int  s  = j / SLOT;
            int  o  = j % SLOT;
            logic em = slots[s] && (((o / 32) % 2) == 0);
            if (busy_o !== 1'b1 || done_o !== 1'b0) err_busy++;
            if (mod_o !== em) begin
                if (s < 8)               err_open++;
                else if (s < 8 + 2*n)    err_data++;
                else                     err_close++;
                if (slots[s]) err_on++; else err_off++;
            end
            if (poke && j == 1000) begin
                start_i = 1'b1; nbits_i = 5'd3; data_i = ~d;
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
        end
        start_i = 1'b0;
        check(err_busy == 0, poke ? "R9 busy length under poke" : "R2 busy length", err_busy, 0);
        check(err_open == 0, "R5 opening marker slots", err_open, 0);
        check(err_data == 0, poke ? "R9 data kept under poke" : "R6 data slot pairs", err_data, 0);
        check(err_close == 0, "R7 closing marker slots", err_close, 0);
        check(err_on == 0, "R3 subcarrier in modulated slots", err_on, 0);
        check(err_off == 0, "R4 quiet in unmodulated slots", err_off, 0);
        check(busy_o == 1'b0 && done_o == 1'b1, "R8 done in first idle cycle",
              {busy_o, done_o}, 1);
        check(mod_o == 1'b0, "R11 idle output low", mod_o, 0);
        @(negedge clk);
        check(done_o == 1'b0, "R8 done lasts one cycle", done_o, 0);
    endtask

    task automatic test_reset();
        check(busy_o == 0 && done_o == 0 && mod_o == 0, "R1 reset state",
              {busy_o, done_o, mod_o}, 0);
    endtask

    task automatic test_bad_count(input int n);
        int seen = 0;
        start_i = 1'b1; nbits_i = NBW'(n); data_i = 16'hFFFF;
        @(negedge clk);
        start_i = 1'b0;
        for (int j = 0; j < 600; j++) begin
            if (busy_o || mod_o || done_o) seen++;
            @(negedge clk);
        end
        check(seen == 0, "R10 bad bit count ignored", seen, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=expired expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        run_frame(1, 16'h0001, 1'b0);
        run_frame(16, 16'hA5C3, 1'b0);
        run_frame(5, 16'h0000, 1'b0);
        run_frame(8, 16'h00FF, 1'b0);
        run_frame(4, 16'h0006, 1'b1);
        test_bad_count(0);
        test_bad_count(17);
        run_frame(2, 16'h0002, 1'b0);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule